// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer with Refresh

This block connects a simple request/acknowledge processor bus to an asynchronous dynamic RAM whose address pins are shared between row and column. Each host address is split into a high row field and a low column field. The row goes out on the shared bus when the row strobe falls. The column goes out when the column strobe falls. The block produces the four active-low strobes (row select, column select, write enable, output enable) for single reads, single writes, read-modify-write and page-mode bursts that stay within one row.

Every strobe phase lasts a parameterised number of clock cycles: row-to-column delay, column pulse width and the precharge recovery gap with the row strobe high. An interval counter schedules refresh cycles of the column-before-row kind, in which the DRAM produces the row address itself. A refresh is granted only from the idle state. When a refresh and a host request wait together, the refresh goes first. An open page is closed when a refresh falls due. After reset, eight refresh cycles run before the first host access is accepted.

Top module: `dram_seq_ctrl`

## Requirements
- R1: The row field is host address bits [ADDR_W-1:COL_W] and the column field is bits [COL_W-1:0]. The row field is on `mem_addr` when `mem_ras_n` falls, and the column field is on `mem_addr` when `mem_cas_n` falls during an access.
- R2: During the column phase of a read, `mem_oe_n` is low and `mem_we_n` is high. `host_rdata` returns the DRAM data sampled at the end of that phase.
- R3: During the column phase of a write, `mem_we_n` is low, `mem_dq_oe` is high with `host_wdata` on `mem_dq_out`, and `mem_oe_n` is high.
- R4: A read-modify-write (`host_rmw`=1) keeps both strobes low. It first reads with `mem_oe_n` low and returns the old data, then pulses `mem_we_n` low to write `host_wdata`. `mem_oe_n` and `mem_we_n` are never low together.
- R5: An access with `host_keep`=1 leaves `mem_ras_n` low after its acknowledge. A following request to the same row toggles only `mem_cas_n`. A request to a different row closes the row first and opens it again with a new row-strobe fall.
- R6: Between two low periods of `mem_ras_n` it stays high for at least T_RP cycles.
- R7: `mem_cas_n` falls at least T_RCD cycles after `mem_ras_n` falls, and each low pulse of `mem_cas_n` lasts at least T_CAS cycles.
- R8: In a refresh, `mem_cas_n` falls while `mem_ras_n` is high, and `mem_ras_n` falls later while `mem_cas_n` stays low. `mem_we_n` and `mem_oe_n` stay high.
- R9: One refresh becomes due every REF_PERIOD cycles. When the block is idle, consecutive refreshes are exactly REF_PERIOD cycles apart. A due refresh runs before a waiting host request.
- R10: After reset, INIT_REFRESH (8) refresh cycles finish before the first `host_ack`.
- R11: `host_ack` is high for exactly one cycle per completed access.
- R12: In reset, all four strobes are high, and `host_ack` and `mem_dq_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_rmw | input | 1 | 1 = read-modify-write (overrides host_we) |
| host_keep | input | 1 | Keep the row open after this access |
| host_addr | input | ADDR_W | Word address (row high, column low) |
| host_wdata | input | DATA_W | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data (old data for read-modify-write) |
| mem_addr | output | MUX_W | Shared row/column address bus |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data to the DRAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the DRAM |

## Verification
A refresh coming due and a host request can both be waiting when the sequencer returns to idle. To provoke this, the bench opens a page and lets it sit until the sequencer closes it for the refresh. The bench raises a read request in the first precharge cycle, so both are waiting when idle is reached. The DRAM model records the kind of the next row-strobe fall: it must be a column-before-row refresh, and the read that follows must return the stored data.

// File: rtl/dram_seq_pkg.sv
// Package: state encoding shared by the DRAM access sequencer.
package dram_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // row strobe high, nothing in flight
        ST_ROW,    // row address out, row strobe low
        ST_COL,    // column address out, column strobe low (read or write)
        ST_WBACK,  // read-modify-write: write pulse under held strobes
        ST_OPEN,   // page held open, column strobe high
        ST_PRECH,  // precharge recovery, row strobe high
        ST_RF_CAS, // refresh: column strobe leads
        ST_RF_RAS  // refresh: row strobe follows
    } seq_state_e;
endpackage

// File: rtl/dram_addr_mux.sv
// Module: dram_addr_mux
// Drives either the row or the column field onto the shared address bus.
// Assumes MUX_W is at least the wider of the two fields; narrower fields
// are zero-extended.
module dram_addr_mux #(
    parameter int ROW_W = 5,
    parameter int COL_W = 5,
    parameter int MUX_W = 5
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             sel_col,
    output logic [MUX_W-1:0] bus
);
    // Select the active field for the current strobe phase.
    always_comb begin
        bus = sel_col ? MUX_W'(col) : MUX_W'(row);
    end
endmodule

// File: rtl/dram_refresh_sched.sv
// Module: dram_refresh_sched
// Free-running interval timer that tracks how many refreshes are owed.
// It starts with INIT_CNT owed refreshes after reset. Assumes one grant
// retires one owed refresh; the owed count saturates instead of wrapping.
module dram_refresh_sched #(
    parameter int PERIOD   = 200,
    parameter int INIT_CNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic pend
);
    localparam int PW = $clog2(PERIOD);
    localparam int OW = $clog2(INIT_CNT + 2) + 1;

    logic [PW-1:0] tmr;
    logic [OW-1:0] owed;
    logic          tick;

    assign tick = (tmr == PW'(PERIOD - 1));
    assign pend = (owed != '0);

    // Interval timer: wraps every PERIOD cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    tmr <= '0;
        else if (tick) tmr <= '0;
        else           tmr <= tmr + 1'b1;
    end

    // Owed-refresh count: add one on a tick, remove one on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) owed <= OW'(INIT_CNT);
        else begin
            case ({tick, grant})
                2'b10:   if (owed != '1) owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assert_grant_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> pend) else $error("refresh granted with none owed");
    assert_owed_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (owed == '1) |=> (owed != '0)) else $error("owed count wrapped");
endmodule

// File: rtl/dram_seq_ctrl.sv
// Module: dram_seq_ctrl
// Sequences row/column strobes for reads, writes, read-modify-write and
// page-mode accesses to an asynchronous DRAM, with periodic
// column-before-row refresh. Assumes the host holds host_req and its
// fields stable until host_ack, and all T_* parameters are at least 1.
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int COL_W        = 5,
    parameter int DATA_W       = 8,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 3,
    parameter int REF_PERIOD   = 200,
    parameter int INIT_REFRESH = 8,
    localparam int ROW_W = ADDR_W - COL_W,
    localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_rmw,
    input  logic              host_keep,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [MUX_W-1:0]  mem_addr,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int TMAX = (T_RP > T_RCD) ? ((T_RP > T_CAS) ? T_RP : T_CAS)
                                         : ((T_RCD > T_CAS) ? T_RCD : T_CAS);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int IW   = $clog2(INIT_REFRESH + 1);

    seq_state_e        state;
    logic [TW-1:0]     tcnt;
    logic [ROW_W-1:0]  a_row;
    logic [COL_W-1:0]  a_col;
    logic              a_we, a_rmw, a_keep;
    logic [DATA_W-1:0] a_wdata;
    logic              ref_pend, ref_grant, sel_col, rd_phase;
    logic [IW-1:0]     init_cnt;

    assign ref_grant = (state == ST_IDLE) && ref_pend;
    assign sel_col   = (state == ST_COL) || (state == ST_WBACK);
    assign rd_phase  = (state == ST_COL) && (!a_we || a_rmw);

    dram_refresh_sched #(.PERIOD(REF_PERIOD), .INIT_CNT(INIT_REFRESH)) u_ref (
        .clk(clk), .rst_n(rst_n), .grant(ref_grant), .pend(ref_pend));

    dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_amux (
        .row(a_row), .col(a_col), .sel_col(sel_col), .bus(mem_addr));

    // Strobe decode from the sequencer state.
    always_comb begin
        mem_ras_n  = !(state inside {ST_ROW, ST_COL, ST_WBACK, ST_OPEN, ST_RF_RAS});
        mem_cas_n  = !(state inside {ST_COL, ST_WBACK, ST_RF_CAS, ST_RF_RAS});
        mem_oe_n   = !rd_phase;
        mem_we_n   = !(((state == ST_COL) && a_we && !a_rmw) || (state == ST_WBACK));
        mem_dq_oe  = !mem_we_n;
        mem_dq_out = a_wdata;
    end

    // Main sequencer: state, phase counter, latched request, ack and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tcnt       <= '0;
            a_row      <= '0;
            a_col      <= '0;
            a_we       <= 1'b0;
            a_rmw      <= 1'b0;
            a_keep     <= 1'b0;
            a_wdata    <= '0;
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack <= 1'b0;
            if (tcnt != '0) tcnt <= tcnt - 1'b1;
            case (state)
                ST_IDLE: begin
                    if (ref_pend) begin
                        state <= ST_RF_CAS;
                        tcnt  <= TW'(T_CAS - 1);
                    end else if (host_req) begin
                        a_row   <= host_addr[ADDR_W-1:COL_W];
                        a_col   <= host_addr[COL_W-1:0];
                        a_we    <= host_we;
                        a_rmw   <= host_rmw;
                        a_keep  <= host_keep;
                        a_wdata <= host_wdata;
                        state   <= ST_ROW;
                        tcnt    <= TW'(T_RCD - 1);
                    end
                end
                ST_ROW: if (tcnt == '0) begin
                    state <= ST_COL;
                    tcnt  <= TW'(T_CAS - 1);
                end
                ST_COL: if (tcnt == '0) begin
                    if (!a_we || a_rmw) host_rdata <= mem_dq_in;
                    if (a_rmw) begin
                        state <= ST_WBACK;
                        tcnt  <= TW'(T_CAS - 1);
                    end else begin
                        host_ack <= 1'b1;
                        state    <= a_keep ? ST_OPEN : ST_PRECH;
                        tcnt     <= a_keep ? '0 : TW'(T_RP - 1);
                    end
                end
                ST_WBACK: if (tcnt == '0) begin
                    host_ack <= 1'b1;
                    state    <= a_keep ? ST_OPEN : ST_PRECH;
                    tcnt     <= a_keep ? '0 : TW'(T_RP - 1);
                end
                ST_OPEN: begin
                    if (ref_pend) begin
                        state <= ST_PRECH;
                        tcnt  <= TW'(T_RP - 1);
                    end else if (host_req && !host_ack) begin
                        if (host_addr[ADDR_W-1:COL_W] == a_row) begin
                            a_col   <= host_addr[COL_W-1:0];
                            a_we    <= host_we;
                            a_rmw   <= host_rmw;
                            a_keep  <= host_keep;
                            a_wdata <= host_wdata;
                            state   <= ST_COL;
                            tcnt    <= TW'(T_CAS - 1);
                        end else begin
                            state <= ST_PRECH;
                            tcnt  <= TW'(T_RP - 1);
                        end
                    end
                end
                ST_PRECH: if (tcnt == '0) state <= ST_IDLE;
                ST_RF_CAS: if (tcnt == '0) begin
                    state <= ST_RF_RAS;
                    tcnt  <= TW'(T_CAS - 1);
                end
                ST_RF_RAS: if (tcnt == '0) begin
                    state <= ST_PRECH;
                    tcnt  <= TW'(T_RP - 1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Count completed start-up refreshes, saturating at INIT_REFRESH.
    always_ff @(posedge clk) begin
        if (!rst_n) init_cnt <= '0;
        else if (state == ST_RF_RAS && tcnt == '0 && init_cnt != IW'(INIT_REFRESH))
            init_cnt <= init_cnt + 1'b1;
    end

    // ---------------- timing monitors for the assertions ----------------
    logic [TW-1:0] hi_cnt, rcd_cnt, cas_cnt;

    // Cycles the row strobe has been high (saturating; precharged at reset).
    always_ff @(posedge clk) begin
        if (!rst_n)          hi_cnt <= TW'(T_RP);
        else if (!mem_ras_n) hi_cnt <= '0;
        else if (hi_cnt != TW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
    end

    // Cycles the row strobe has been low (saturating at T_RCD).
    always_ff @(posedge clk) begin
        if (!rst_n)         rcd_cnt <= '0;
        else if (mem_ras_n) rcd_cnt <= '0;
        else if (rcd_cnt != TW'(T_RCD)) rcd_cnt <= rcd_cnt + 1'b1;
    end

    // Cycles the column strobe has been low (saturating at T_CAS).
    always_ff @(posedge clk) begin
        if (!rst_n)         cas_cnt <= '0;
        else if (mem_cas_n) cas_cnt <= '0;
        else if (cas_cnt != TW'(T_CAS)) cas_cnt <= cas_cnt + 1'b1;
    end

    assert_prech_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (hi_cnt >= TW'(T_RP))) else $error("precharge gap short");
    assert_rcd_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cas_n) && !mem_ras_n) |-> (rcd_cnt >= TW'(T_RCD))) else $error("RAS-to-CAS short");
    assert_cas_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cas_n) |-> (cas_cnt >= TW'(T_CAS))) else $error("CAS pulse short");
    assert_ras_cas_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> $stable(mem_cas_n)) else $error("strobes fell together");
    assert_refresh_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cas_n && mem_ras_n) |-> (mem_we_n && mem_oe_n)) else $error("data strobe in refresh");
    assert_oe_we_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)) else $error("OE and WE low together");
    assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack) else $error("ack longer than one cycle");
    assert_init_before_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (init_cnt == IW'(INIT_REFRESH))) else $error("ack before start-up refreshes");
endmodule

// File: tb/test_dram_seq_ctrl.sv
// Bench for dram_seq_ctrl: a cycle-sampled DRAM model plus a vector table
// followed by directed page-mode, priority, refresh-interval and timing checks.
module test_dram_seq_ctrl;
    localparam int ADDR_W = 10, COL_W = 5, DATA_W = 8;
    localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, REF_PERIOD = 200, INIT_REFRESH = 8;
    localparam int NVEC = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_req = 0, host_we = 0, host_rmw = 0, host_keep = 0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic host_ack;
    logic [DATA_W-1:0] host_rdata;
    logic [4:0] mem_addr;
    logic mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DATA_W-1:0] mem_dq_out, mem_dq_in;

    int checks = 0, errors = 0, cycle = 0;

    always #5 clk = ~clk;

    dram_seq_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
        .T_CAS(T_CAS), .T_RP(T_RP), .REF_PERIOD(REF_PERIOD), .INIT_REFRESH(INIT_REFRESH))
    i_dram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_rmw(host_rmw), .host_keep(host_keep), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    // ---------------- DRAM model, sampled at the falling clock edge ----------------
    logic [DATA_W-1:0] mem [1024];
    logic [4:0] m_row = '0, m_col = '0;
    logic p_ras = 1'b1, p_cas = 1'b1;
    int acc_falls = 0, col_falls = 0, ref_cnt = 0, last_ref = 0, ref_gap = 0;
    int hi_run = 1000, rcd_run = 0, cas_run = 0;
    int min_hi = 1000, min_rcd = 1000, min_cas = 1000;
    bit watch_on = 0;
    int watch_kind = 0; // 0 none seen, 1 access fall, 2 refresh fall

    assign mem_dq_in = mem_oe_n ? '0 : mem[{m_row, m_col}];

    always @(negedge clk) begin
        cycle = cycle + 1;
        if (rst_n) begin
            if (p_ras && !mem_ras_n) begin
                if (hi_run < min_hi) min_hi = hi_run;
                hi_run = 0;
                rcd_run = 0;
                if (!mem_cas_n) begin
                    ref_cnt = ref_cnt + 1;
                    ref_gap = cycle - last_ref;
                    last_ref = cycle;
                    if (watch_on && watch_kind == 0) watch_kind = 2;
                end else begin
                    m_row = mem_addr;
                    acc_falls = acc_falls + 1;
                    if (watch_on && watch_kind == 0) watch_kind = 1;
                end
            end
            if (mem_ras_n) hi_run = hi_run + 1;
            if (!mem_ras_n && mem_cas_n) rcd_run = rcd_run + 1;
            if (p_cas && !mem_cas_n) begin
                cas_run = 0;
                if (!mem_ras_n) begin
                    m_col = mem_addr;
                    col_falls = col_falls + 1;
                    if (rcd_run < min_rcd) min_rcd = rcd_run;
                end
            end
            if (!p_cas && mem_cas_n && cas_run < min_cas) min_cas = cas_run;
            if (!mem_cas_n) cas_run = cas_run + 1;
            if (!mem_ras_n && !mem_cas_n && !mem_we_n && mem_dq_oe)
                mem[{m_row, m_col}] = mem_dq_out;
        end
        p_ras = mem_ras_n;
        p_cas = mem_cas_n;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic rmw, input logic keep,
                          input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                          output logic [DATA_W-1:0] rd);
        @(negedge clk);
        host_req = 1; host_we = we; host_rmw = rmw; host_keep = keep;
        host_addr = a; host_wdata = wd;
        @(negedge clk);
        while (!host_ack) @(negedge clk);
        rd = host_rdata;
        host_req = 0;
        @(negedge clk);
        chk(host_ack == 1'b0, "R11 ack single cycle", int'(host_ack), 0);
    endtask

    // Vector table: {we, rmw, addr[9:0], wdata, expected rdata}
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 10'h000, 8'hA5, 8'h00},
        {1'b1, 1'b0, 10'h3FF, 8'h3C, 8'h00},
        {1'b1, 1'b0, 10'h021, 8'h77, 8'h00},
        {1'b1, 1'b0, 10'h201, 8'h11, 8'h00},
        {1'b0, 1'b0, 10'h000, 8'h00, 8'hA5},
        {1'b0, 1'b0, 10'h3FF, 8'h00, 8'h3C},
        {1'b0, 1'b0, 10'h021, 8'h00, 8'h77},
        {1'b0, 1'b0, 10'h201, 8'h00, 8'h11},
        {1'b0, 1'b1, 10'h021, 8'h99, 8'h77},
        {1'b0, 1'b0, 10'h021, 8'h00, 8'h99}
    };

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        while (cycle < 150000) @(negedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycle, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd;
        int r0, c0, r1;
        for (int i = 0; i < 1024; i++) mem[i] = '0;

        // R12: reset state
        repeat (4) @(negedge clk);
        chk({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, host_ack, mem_dq_oe} == 6'b111100,
            "R12 reset outputs", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, host_ack, mem_dq_oe}, 6'b111100);
        @(negedge clk) rst_n = 1;

        // Table walk: R1 address split, R2 read, R3 write, R4 read-modify-write, R10 start-up
        for (int i = 0; i < NVEC; i++) begin
            logic [27:0] v;
            v = VEC[i];
            access(v[27], v[26], 1'b0, v[25:16], v[15:8], rd);
            if (i == 0)
                chk(ref_cnt == INIT_REFRESH, "R10 refreshes before first ack", ref_cnt, INIT_REFRESH);
            if (v[26]) begin
                chk(rd == v[7:0], "R4 rmw returns old data", rd, v[7:0]);
                chk(mem[v[25:16]] == v[15:8], "R4 rmw writes new data", mem[v[25:16]], v[15:8]);
            end else if (v[27]) begin
                chk(mem[v[25:16]] == v[15:8], "R1 R3 write lands at row/col", mem[v[25:16]], v[15:8]);
            end else begin
                chk(rd == v[7:0], "R1 R2 read data", rd, v[7:0]);
            end
        end

        // R5: page mode within one row, then a row change
        access(1'b1, 1'b0, 1'b1, 10'h040, 8'h50, rd);
        r0 = acc_falls; c0 = col_falls;
        access(1'b1, 1'b0, 1'b1, 10'h045, 8'h55, rd);
        chk(acc_falls == r0, "R5 same row keeps RAS low", acc_falls, r0);
        chk(col_falls == c0 + 1, "R5 one CAS per page access", col_falls, c0 + 1);
        chk(mem[10'h045] == 8'h55, "R5 page write data", mem[10'h045], 8'h55);
        access(1'b0, 1'b0, 1'b1, 10'h040, 8'h00, rd);
        chk(acc_falls == r0 && rd == 8'h50, "R5 page read in open row", rd, 8'h50);
        access(1'b0, 1'b0, 1'b0, 10'h3FF, 8'h00, rd);
        chk(acc_falls == r0 + 1, "R5 row change reopens", acc_falls, r0 + 1);
        chk(rd == 8'h3C, "R5 row change read data", rd, 8'h3C);

        // R9: refresh and host request waiting together at idle
        access(1'b1, 1'b0, 1'b1, 10'h0A3, 8'hC3, rd);
        while (!mem_ras_n) @(negedge clk);
        watch_on = 1; watch_kind = 0;
        access(1'b0, 1'b0, 1'b0, 10'h0A3, 8'h00, rd);
        chk(watch_kind == 2, "R9 refresh before waiting request", watch_kind, 2);
        chk(rd == 8'hC3, "R9 request served after refresh", rd, 8'hC3);
        watch_on = 0;

        // R9: idle refresh spacing
        r1 = ref_cnt;
        while (ref_cnt < r1 + 3) @(negedge clk);
        chk(ref_gap == REF_PERIOD, "R9 idle refresh interval", ref_gap, REF_PERIOD);

        // R6, R7, R8: timing minima and refresh count seen by the model
        chk(min_hi >= T_RP, "R6 precharge gap", min_hi, T_RP);
        chk(min_rcd >= T_RCD, "R7 RAS-to-CAS delay", min_rcd, T_RCD);
        chk(min_cas >= T_CAS, "R7 CAS pulse width", min_cas, T_CAS);
        chk(ref_cnt >= INIT_REFRESH + 3, "R8 refresh cycles recognised", ref_cnt, INIT_REFRESH + 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule